// File: doc/BRIEF.md
# Address generator hazard detector

This block sits beside the issue stage of a simple in-order pipeline that drives two address generators. Each generator owns four register classes: index, modify, length and base. Each cycle the block sees the address-generator register that the issuing instruction writes and the index and modify registers it reads. It also sees whether the instruction moves an address-generator register to or from memory, the addressing mode it uses, and the bus each concurrent operation requests.

The block combines three checks. A write/read dependency check keeps a one-entry record of the last register written and compares it against the next instruction's reads. The comparison works per odd/even register pair, so the outcome depends on the exact register number and on whether the write was a long-word access. A bus check flags two operations that want the same bus in one cycle. A legality check flags transfers that address memory through the same generator that owns the transferred register. The stall is a combinational function of the write record and the current reads, so the issue logic can hold the instruction in the same cycle. The two flags are registered and report one cycle after the instruction they describe.

Top module: `agen_hazard_unit`

## Requirements
- R1: When an instruction writes index or modify register k (class code 0 = index, 1 = modify, 2 = length, 3 = base) and is not stalled, and the next presented instruction reads register k of the same class, `stall` is high in that next cycle.
- R2: When the next instruction reads the other member of the written register's pair, `stall` is high only if the write had `wr_long` set. Registers 2j and 2j+1 form a pair.
- R3: A read in a different pair, a different generator (register numbers 0–7 belong to the first generator, 8–15 to the second) or a different class than the recorded write never raises `stall`.
- R4: `stall` never stays high for two cycles in a row. The write record is dropped in a stall cycle, and the stalled instruction's own write is not recorded. When the same instruction is presented again in the next cycle, it does not stall and its write is recorded. `illegal_op` reports only instructions presented without a stall.
- R5: `bus_delay` is high in the cycle after two or more requesting operations named the same bus number. It is low in the cycle after requests that all named different buses, or after fewer than two requests.
- R6: A store (`xfer_store` = 1) of register `xfer_num` addressed through index register `rd_i_num` of the same generator sets `illegal_op` in the next cycle. This holds for both pre-modify and post-modify addressing (`post_mod` = 1 for post-modify).
- R7: A load (`xfer_store` = 0) addressed through the same generator with post-modify sets `illegal_op` in the next cycle.
- R8: A load through the same generator with pre-modify, and any transfer through the other generator, leave `illegal_op` low in the next cycle.
- R9: A synchronous active-high `rst` clears the write record and drives `stall`, `bus_delay` and `illegal_op` low. A read of the register written during reset does not stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Current instruction writes an address-generator register |
| wr_cls | input | 2 | Class of the written register (0 index, 1 modify, 2 length, 3 base) |
| wr_num | input | NUM_W | Number of the written register |
| wr_long | input | 1 | The write is a long-word access |
| rd_i_en | input | 1 | Current instruction reads an index register |
| rd_i_num | input | NUM_W | Index register read (also the addressing index) |
| rd_m_en | input | 1 | Current instruction reads a modify register |
| rd_m_num | input | NUM_W | Modify register read |
| xfer_en | input | 1 | Instruction moves an address-generator register to or from memory |
| xfer_store | input | 1 | 1 = store to memory, 0 = load from memory |
| xfer_num | input | NUM_W | Number of the transferred register |
| post_mod | input | 1 | 1 = post-modify (index update), 0 = pre-modify |
| op_req | input | NOPS | Per-operation bus request |
| op_bus | input | NOPS*BUS_W | Bus number requested by each operation, operation 0 in the low bits |
| stall | output | 1 | Hold the presented instruction this cycle |
| bus_delay | output | 1 | A bus conflict occurred in the previous cycle |
| illegal_op | output | 1 | The instruction issued in the previous cycle was an illegal combination |

## Verification
The assertions take for granted that the environment presents a stalled instruction again unchanged in the next cycle. The legality assertions also assume that an addressing index is read whenever a transfer is flagged. The dependency assertions look only one cycle back and discount the first cycle after reset. The bench drives every scenario from an idle cycle with no pending write, so each check sees only the record its own task created. It presents a stalled instruction again unchanged.

// File: rtl/agh_pkg.sv
`timescale 1ns/1ps
package agh_pkg;
  localparam int REG_NUM_W = 4;
  typedef enum logic [1:0] {
    CLS_I = 2'd0,
    CLS_M = 2'd1,
    CLS_L = 2'd2,
    CLS_B = 2'd3
  } dag_cls_e;
endpackage

// File: rtl/agh_dep_tracker.sv
`timescale 1ns/1ps
module agh_dep_tracker
  import agh_pkg::*;
#(
  parameter int NUM_W = REG_NUM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  dag_cls_e         wr_cls,
  input  logic [NUM_W-1:0] wr_num,
  input  logic             wr_long,
  input  logic             rd_i_en,
  input  logic [NUM_W-1:0] rd_i_num,
  input  logic             rd_m_en,
  input  logic [NUM_W-1:0] rd_m_num,
  output logic             stall
);
  localparam int NPORT = 2;
  localparam int MSB   = NUM_W - 1;

  logic             rec_vld;
  dag_cls_e         rec_cls;
  logic [NUM_W-1:0] rec_num;
  logic             rec_long;

  // one-entry write record; a stall consumes it and ignores the held write
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_vld  <= 1'b0;
      rec_cls  <= CLS_I;
      rec_num  <= '0;
      rec_long <= 1'b0;
    end else if (stall) begin
      rec_vld  <= 1'b0;
    end else begin
      rec_vld  <= wr_en;
      rec_cls  <= wr_cls;
      rec_num  <= wr_num;
      rec_long <= wr_long;
    end
  end

  logic             port_en  [NPORT];
  logic [NUM_W-1:0] port_num [NPORT];
  logic [NPORT-1:0] port_hit;

  assign port_en[0]  = rd_i_en;
  assign port_num[0] = rd_i_num;
  assign port_en[1]  = rd_m_en;
  assign port_num[1] = rd_m_num;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam dag_cls_e PCLS = (p == 0) ? CLS_I : CLS_M;
    logic cls_ok, same_pair, exact;
    assign cls_ok    = rec_vld && port_en[p] && (rec_cls == PCLS);
    assign same_pair = rec_num[MSB:1] == port_num[p][MSB:1];
    assign exact     = same_pair && (rec_num[0] == port_num[p][0]);
    assign port_hit[p] = cls_ok && same_pair && (exact || rec_long);
  end

  assign stall = |port_hit;

  AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall); // R4

  AST_SAME_REG_STALL: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !stall && wr_cls == CLS_I) && rd_i_en &&
     rd_i_num == $past(wr_num)) |-> stall); // R1

  AST_OTHER_GEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && wr_en && !stall) &&
     (!rd_i_en || rd_i_num[MSB] != $past(wr_num[MSB])) &&
     (!rd_m_en || rd_m_num[MSB] != $past(wr_num[MSB]))) |-> !stall); // R3
endmodule

// File: rtl/agh_bus_check.sv
`timescale 1ns/1ps
module agh_bus_check #(
  parameter int NOPS  = 3,
  parameter int BUS_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NOPS-1:0]       op_req,
  input  logic [NOPS*BUS_W-1:0] op_bus,
  output logic                  bus_delay
);
  localparam int NCMP = NOPS * NOPS;

  logic [NCMP-1:0] clash;

  for (genvar a = 0; a < NOPS; a++) begin : g_a
    for (genvar b = 0; b < NOPS; b++) begin : g_b
      if (b > a) begin : g_cmp
        assign clash[a*NOPS+b] = op_req[a] && op_req[b] &&
          (op_bus[a*BUS_W +: BUS_W] == op_bus[b*BUS_W +: BUS_W]);
      end else begin : g_none
        assign clash[a*NOPS+b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_delay <= 1'b0;
    else     bus_delay <= |clash;
  end

  AST_ONE_REQ_NO_DELAY: assert property (@(posedge clk) disable iff (rst)
    ($countones(op_req) <= 1) |=> !bus_delay); // R5
endmodule

// File: rtl/agh_illegal_check.sv
`timescale 1ns/1ps
module agh_illegal_check
  import agh_pkg::*;
#(
  parameter int NUM_W = REG_NUM_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_ok,
  input  logic             xfer_en,
  input  logic             xfer_store,
  input  logic [NUM_W-1:0] xfer_num,
  input  logic             rd_i_en,
  input  logic [NUM_W-1:0] rd_i_num,
  input  logic             post_mod,
  output logic             illegal_op
);
  localparam int GEN_BIT = NUM_W - 1;

  logic same_gen, bad_store, bad_load;

  assign same_gen  = rd_i_en && (xfer_num[GEN_BIT] == rd_i_num[GEN_BIT]);
  assign bad_store = xfer_en && xfer_store && same_gen;
  assign bad_load  = xfer_en && !xfer_store && post_mod && same_gen;

  always_ff @(posedge clk) begin
    if (rst) illegal_op <= 1'b0;
    else     illegal_op <= issue_ok && (bad_store || bad_load);
  end

  AST_STORE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && xfer_en && xfer_store && rd_i_en &&
     xfer_num[GEN_BIT] == rd_i_num[GEN_BIT]) |=> illegal_op); // R6

  AST_LOAD_POST_FLAG: assert property (@(posedge clk) disable iff (rst)
    (issue_ok && xfer_en && !xfer_store && post_mod && rd_i_en &&
     xfer_num[GEN_BIT] == rd_i_num[GEN_BIT]) |=> illegal_op); // R7

  AST_LOAD_PRE_OK: assert property (@(posedge clk) disable iff (rst)
    (xfer_en && !xfer_store && !post_mod) |=> !illegal_op); // R8
endmodule

// File: rtl/agen_hazard_unit.sv
`timescale 1ns/1ps
module agen_hazard_unit
  import agh_pkg::*;
#(
  parameter int NUM_W = REG_NUM_W,
  parameter int NOPS  = 3,
  parameter int BUS_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [1:0]            wr_cls,
  input  logic [NUM_W-1:0]      wr_num,
  input  logic                  wr_long,
  input  logic                  rd_i_en,
  input  logic [NUM_W-1:0]      rd_i_num,
  input  logic                  rd_m_en,
  input  logic [NUM_W-1:0]      rd_m_num,
  input  logic                  xfer_en,
  input  logic                  xfer_store,
  input  logic [NUM_W-1:0]      xfer_num,
  input  logic                  post_mod,
  input  logic [NOPS-1:0]       op_req,
  input  logic [NOPS*BUS_W-1:0] op_bus,
  output logic                  stall,
  output logic                  bus_delay,
  output logic                  illegal_op
);
  dag_cls_e wr_cls_e;
  logic     stall_w;

  assign wr_cls_e = dag_cls_e'(wr_cls);
  assign stall    = stall_w;

  agh_dep_tracker #(.NUM_W(NUM_W)) i_dep (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_cls   (wr_cls_e),
    .wr_num   (wr_num),
    .wr_long  (wr_long),
    .rd_i_en  (rd_i_en),
    .rd_i_num (rd_i_num),
    .rd_m_en  (rd_m_en),
    .rd_m_num (rd_m_num),
    .stall    (stall_w)
  );

  agh_bus_check #(.NOPS(NOPS), .BUS_W(BUS_W)) i_bus (
    .clk       (clk),
    .rst       (rst),
    .op_req    (op_req),
    .op_bus    (op_bus),
    .bus_delay (bus_delay)
  );

  agh_illegal_check #(.NUM_W(NUM_W)) i_ill (
    .clk        (clk),
    .rst        (rst),
    .issue_ok   (!stall_w),
    .xfer_en    (xfer_en),
    .xfer_store (xfer_store),
    .xfer_num   (xfer_num),
    .rd_i_en    (rd_i_en),
    .rd_i_num   (rd_i_num),
    .post_mod   (post_mod),
    .illegal_op (illegal_op)
  );
endmodule

// File: tb/test_agen_hazard_unit.sv
`timescale 1ns/1ps
module test_agen_hazard_unit;
  localparam int NUM_W = 4;
  localparam int NOPS  = 3;
  localparam int BUS_W = 2;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, wr_long, rd_i_en, rd_m_en, xfer_en, xfer_store, post_mod;
  logic [1:0] wr_cls;
  logic [NUM_W-1:0] wr_num, rd_i_num, rd_m_num, xfer_num;
  logic [NOPS-1:0] op_req;
  logic [NOPS*BUS_W-1:0] op_bus;
  logic stall, bus_delay, illegal_op;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  agen_hazard_unit #(.NUM_W(NUM_W), .NOPS(NOPS), .BUS_W(BUS_W)) i_agen_hazard_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cls(wr_cls), .wr_num(wr_num),
    .wr_long(wr_long), .rd_i_en(rd_i_en), .rd_i_num(rd_i_num),
    .rd_m_en(rd_m_en), .rd_m_num(rd_m_num), .xfer_en(xfer_en),
    .xfer_store(xfer_store), .xfer_num(xfer_num), .post_mod(post_mod),
    .op_req(op_req), .op_bus(op_bus), .stall(stall),
    .bus_delay(bus_delay), .illegal_op(illegal_op)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_cls = 0; wr_num = 0; wr_long = 0;
    rd_i_en = 0; rd_i_num = 0; rd_m_en = 0; rd_m_num = 0;
    xfer_en = 0; xfer_store = 0; xfer_num = 0; post_mod = 0;
    op_req = 0; op_bus = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // write in one cycle, read in the next; returns stall seen with the read
  task automatic wr_then_rd(input logic [1:0] cls, input logic [3:0] wn,
                            input logic lw, input logic is_m,
                            input logic [3:0] rn, output logic st);
    idle();
    tick();
    wr_en = 1; wr_cls = cls; wr_num = wn; wr_long = lw;
    tick();
    idle();
    if (is_m) begin rd_m_en = 1; rd_m_num = rn; end
    else      begin rd_i_en = 1; rd_i_num = rn; end
    #1 st = stall;
    tick();
    idle();
  endtask

  task automatic t_reset();
    idle();
    rst = 1;
    wr_en = 1; wr_cls = 0; wr_num = 5;
    op_req = 3'b011; op_bus = 6'b000101;
    repeat (3) tick();
    chk("R9 stall in reset", stall, 1'b0);
    chk("R9 bus_delay in reset", bus_delay, 1'b0);
    chk("R9 illegal_op in reset", illegal_op, 1'b0);
    rst = 0;
    idle();
    rd_i_en = 1; rd_i_num = 5;
    #1 chk("R9 write during reset not recorded", stall, 1'b0);
    tick();
    idle();
  endtask

  task automatic t_same_reg();
    logic st;
    wr_then_rd(2'd0, 4'd3, 1'b0, 1'b0, 4'd3, st);
    chk("R1 index I3 then I3", st, 1'b1);
    wr_then_rd(2'd1, 4'd10, 1'b0, 1'b1, 4'd10, st);
    chk("R1 modify M10 then M10", st, 1'b1);
  endtask

  task automatic t_pair();
    logic st;
    wr_then_rd(2'd0, 4'd4, 1'b0, 1'b0, 4'd5, st);
    chk("R2 I4 short then I5", st, 1'b0);
    wr_then_rd(2'd0, 4'd4, 1'b1, 1'b0, 4'd5, st);
    chk("R2 I4 long then I5", st, 1'b1);
    wr_then_rd(2'd1, 4'd9, 1'b1, 1'b1, 4'd8, st);
    chk("R2 M9 long then M8", st, 1'b1);
  endtask

  task automatic t_no_dep();
    logic st;
    wr_then_rd(2'd0, 4'd2, 1'b1, 1'b0, 4'd4, st);
    chk("R3 other pair I2 then I4", st, 1'b0);
    wr_then_rd(2'd0, 4'd1, 1'b1, 1'b0, 4'd9, st);
    chk("R3 other generator I1 then I9", st, 1'b0);
    wr_then_rd(2'd2, 4'd3, 1'b1, 1'b0, 4'd3, st);
    chk("R3 length L3 then index I3", st, 1'b0);
    wr_then_rd(2'd0, 4'd6, 1'b0, 1'b1, 4'd6, st);
    chk("R3 index I6 then modify M6", st, 1'b0);
  endtask

  task automatic t_stall_hold();
    idle();
    tick();
    wr_en = 1; wr_cls = 0; wr_num = 6;
    tick();
    // held instruction: reads I6, writes M1, stores I0 via I6 (same generator)
    idle();
    rd_i_en = 1; rd_i_num = 6; wr_en = 1; wr_cls = 1; wr_num = 1;
    xfer_en = 1; xfer_store = 1; xfer_num = 0;
    #1 chk("R4 first presentation stalls", stall, 1'b1);
    tick();
    chk("R4 no illegal_op for stalled instruction", illegal_op, 1'b0);
    chk("R4 re-presented instruction not stalled", stall, 1'b0);
    tick();
    chk("R4 illegal_op once issued", illegal_op, 1'b1);
    idle();
    rd_m_en = 1; rd_m_num = 1;
    #1 chk("R4 write of issued instruction recorded", stall, 1'b1);
    tick();
    idle();
    tick();
  endtask

  task automatic bus_case(input logic [2:0] req, input logic [5:0] bus,
                          input logic exp, input string msg);
    idle();
    op_req = req; op_bus = bus;
    tick();
    idle();
    chk(msg, bus_delay, exp);
  endtask

  task automatic t_bus();
    bus_case(3'b011, 6'b00_01_01, 1'b1, "R5 ops 0,1 on bus 1");
    bus_case(3'b011, 6'b00_10_01, 1'b0, "R5 ops 0,1 on buses 1,2");
    bus_case(3'b101, 6'b11_00_11, 1'b1, "R5 ops 0,2 on bus 3");
    bus_case(3'b110, 6'b01_10_01, 1'b0, "R5 ops 1,2 on buses 2,1");
    bus_case(3'b001, 6'b01_01_01, 1'b0, "R5 single request");
    bus_case(3'b000, 6'b00_00_00, 1'b0, "R5 no request");
    tick();
  endtask

  task automatic ill_case(input logic st, input logic [3:0] xn,
                          input logic [3:0] idx, input logic pm,
                          input logic exp, input string msg);
    idle();
    tick();
    xfer_en = 1; xfer_store = st; xfer_num = xn;
    rd_i_en = 1; rd_i_num = idx; post_mod = pm;
    tick();
    idle();
    chk(msg, illegal_op, exp);
  endtask

  task automatic t_illegal();
    ill_case(1'b1, 4'd0,  4'd1,  1'b0, 1'b1, "R6 store I0 via I1 pre-modify");
    ill_case(1'b1, 4'd0,  4'd1,  1'b1, 1'b1, "R6 store via I1 post-modify");
    ill_case(1'b1, 4'd12, 4'd9,  1'b0, 1'b1, "R6 store second generator");
    ill_case(1'b1, 4'd9,  4'd1,  1'b1, 1'b0, "R8 store other generator");
    ill_case(1'b0, 4'd2,  4'd1,  1'b1, 1'b1, "R7 load via I1 post-modify");
    ill_case(1'b0, 4'd15, 4'd8,  1'b1, 1'b1, "R7 load second generator post");
    ill_case(1'b0, 4'd2,  4'd1,  1'b0, 1'b0, "R8 load via I1 pre-modify");
    ill_case(1'b0, 4'd12, 4'd3,  1'b1, 1'b0, "R8 load other generator post");
    tick();
    chk("R8 illegal_op clears after idle", illegal_op, 1'b0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    t_reset();
    t_same_reg();
    t_pair();
    t_no_dep();
    t_stall_hold();
    t_bus();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule